// File: doc/BRIEF.md
# Double-Precision Floating-Point Multiply Datapath

This block multiplies two 64-bit binary floating-point operands in double-precision layout. Bit 63 is the sign, bits 62:52 are the biased exponent (bias 1023) and bits 51:0 are the fraction. It returns the 64-bit product together with an overflow flag and an underflow flag. Each operand is split into its fields. The hidden leading one is restored to form a 53-bit significand, and the two significands are multiplied by a radix-4 recoded multiplier. The result sign and the intermediate exponent are formed alongside the multiply.

The 106-bit significand product is then normalized. If its top bit is set, it is taken one place further right and the exponent rises by one. The fraction is cut to 52 bits, with no rounding step, so every result rounds toward zero. Out-of-range exponents force the output to signed infinity or signed zero and raise the matching flag.

Operands enter on a valid/ready handshake, and results leave on another one. When the consumer is ready, the latency is fixed at `PIPE_STAGES + 1` cycles. A stalled output holds every pipeline stage. Denormal encodings are treated as zero, and NaN and infinity inputs get no special treatment.

Top module: `dfp_mul_core`

## Requirements
- R1: The result sign (bit 63) is the XOR of the two operand signs, for normal, zero, overflowed and underflowed results alike.
- R2: For two operands with nonzero exponent fields, the intermediate exponent is Ea + Eb - 1023. When the significand product (1.fa × 1.fb) is below 2, that value is the result exponent in bits 62:52.
- R3: When the significand product is 2 or more, the result exponent is the intermediate exponent plus one, and the fraction comes from product bits 104:53. Otherwise the fraction comes from product bits 103:52.
- R4: The 52-bit result fraction is truncated, never rounded. For example, 25.5 × 75.6 gives the largest double not above the exact product of the two encoded operands.
- R5: If either operand has an exponent field of zero, the result is a zero with the R1 sign, and both flags stay low.
- R6: If the final exponent (after any R3 increment) is 2047 or more, ovf is high and the result is signed infinity: exponent field all ones and fraction zero.
- R7: If the intermediate exponent is below zero, or is zero with no R3 increment, udf is high and the result is signed zero. An intermediate exponent of zero that does receive the R3 increment yields a normal result with exponent 1 and no flag.
- R8: After reset, out_valid is low and in_ready is high. An operand pair is taken on a clock edge where in_valid and in_ready are both high. When out_ready stays high, its result appears PIPE_STAGES + 1 edges later. While out_valid is high and out_ready is low, product, ovf and udf hold steady.
- R9: Under any pattern of input gaps and output stalls, every accepted operand pair produces exactly one result, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block accepts an operand pair this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| product | output | 64 | Packed result |
| ovf | output | 1 | Exponent overflow, result forced to signed infinity |
| udf | output | 1 | Exponent underflow, result forced to signed zero |

## Verification
Most faults in this datapath surface on the very next result that crosses the boundary involved. A wrong bias or carry in the exponent path shifts bits 62:52 of that result. A wrong normalization select corrupts both the fraction and the exponent. A wrong Booth digit corrupts the fraction bits above the cut. Flag-decision faults only appear on operand pairs whose intermediate exponent lands at 0, -1, 2046 or 2047, so those values are driven directly. A pipeline enable or valid fault shows up as a lost, duplicated or reordered result within PIPE_STAGES + 1 cycles of an output stall.

// File: rtl/dfp_mul_pkg.sv
package dfp_mul_pkg;

   // outcome of the normalize stage, in priority order zero > underflow > overflow > normal
   typedef enum logic [1:0] {
      CLS_NORMAL = 2'd0,
      CLS_ZERO   = 2'd1,
      CLS_UNDER  = 2'd2,
      CLS_OVER   = 2'd3
   } dfp_cls_e;

   // radix-4 recoded digit: magnitude select and negate
   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } booth_dig_t;

   function automatic booth_dig_t booth_decode(input logic [2:0] tri_bits);
      booth_dig_t d;
      d.neg = tri_bits[2] & ~(tri_bits[1] & tri_bits[0]);
      d.one = tri_bits[1] ^ tri_bits[0];
      d.two = (tri_bits == 3'b011) | (tri_bits == 3'b100);
      return d;
   endfunction

endpackage

// File: rtl/dfp_field_split.sv
module dfp_field_split #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int SIG_W = FRAC_W + 1,
   localparam int XE_W  = EXP_W + 2
) (
   input  logic [W-1:0]            a_i,
   input  logic [W-1:0]            b_i,
   output logic                    sign_o,
   output logic                    zero_o,
   output logic signed [XE_W-1:0]  exp_o,
   output logic [SIG_W-1:0]        sig_a_o,
   output logic [SIG_W-1:0]        sig_b_o
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;

   logic [EXP_W-1:0] ea, eb;
   logic [XE_W-1:0]  esum;

   assign ea = a_i[W-2 -: EXP_W];
   assign eb = b_i[W-2 -: EXP_W];

   assign sign_o  = a_i[W-1] ^ b_i[W-1];
   assign zero_o  = (ea == '0) || (eb == '0);
   assign sig_a_o = {1'b1, a_i[FRAC_W-1:0]};
   assign sig_b_o = {1'b1, b_i[FRAC_W-1:0]};

   // add in a field two bits wider so the carry survives, then remove the bias
   assign esum  = {2'b00, ea} + {2'b00, eb};
   assign exp_o = $signed(esum - XE_W'(BIAS));

endmodule

// File: rtl/dfp_booth_mul.sv
module dfp_booth_mul #(
   parameter int SIG_W   = 53,
   localparam int MB_W   = ((SIG_W + 2) / 2) * 2,
   localparam int NGRP   = MB_W / 2,
   localparam int PROD_W = 2 * SIG_W
) (
   input  logic [SIG_W-1:0]  a_i,
   input  logic [SIG_W-1:0]  b_i,
   output logic [PROD_W-1:0] p_o
);
   import dfp_mul_pkg::*;

   // multiplier padded with zeros on top (keeps it positive) and one below
   logic [MB_W:0]       ybits;
   logic [PROD_W-1:0]   mcand;
   logic [PROD_W-1:0]   pp [NGRP];

   assign ybits = {{(MB_W - SIG_W){1'b0}}, b_i, 1'b0};
   assign mcand = PROD_W'(a_i);

   for (genvar g = 0; g < NGRP; g++) begin : g_pp
      booth_dig_t        dig;
      logic [PROD_W-1:0] mag;
      logic [PROD_W-1:0] signed_mag;

      assign dig = booth_decode(ybits[2*g+2 -: 3]);

      always_comb begin
         if (dig.two)      mag = mcand << 1;
         else if (dig.one) mag = mcand;
         else              mag = '0;
         signed_mag = dig.neg ? (~mag + PROD_W'(1)) : mag;
      end

      assign pp[g] = signed_mag << (2 * g);
   end

   // modular sum: every term is already cut to the product width
   always_comb begin
      p_o = '0;
      for (int g = 0; g < NGRP; g++) begin
         p_o = p_o + pp[g];
      end
   end

endmodule

// File: rtl/dfp_norm_pack.sv
module dfp_norm_pack #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int XE_W  = EXP_W + 2,
   localparam int KEEP_W = FRAC_W + 2
) (
   input  logic                   sign_i,
   input  logic                   zero_i,
   input  logic signed [XE_W-1:0] exp_i,
   input  logic [KEEP_W-1:0]      prod_hi_i,
   output logic [W-1:0]           res_o,
   output logic                   ovf_o,
   output logic                   udf_o
);
   import dfp_mul_pkg::*;

   localparam int EMAX = (1 << EXP_W) - 1;

   logic                   top;
   logic [FRAC_W-1:0]      frac;
   logic signed [XE_W-1:0] efin;
   dfp_cls_e               cls;

   assign top  = prod_hi_i[KEEP_W-1];
   assign frac = top ? prod_hi_i[KEEP_W-2 -: FRAC_W] : prod_hi_i[KEEP_W-3 -: FRAC_W];
   assign efin = exp_i + $signed({{(XE_W-1){1'b0}}, top});

   always_comb begin
      if (zero_i)                                    cls = CLS_ZERO;
      else if (exp_i < 0 || (exp_i == 0 && !top))    cls = CLS_UNDER;
      else if (efin >= $signed(XE_W'(EMAX)))         cls = CLS_OVER;
      else                                           cls = CLS_NORMAL;
   end

   always_comb begin
      ovf_o = 1'b0;
      udf_o = 1'b0;
      unique case (cls)
         CLS_ZERO:  res_o = {sign_i, {(W-1){1'b0}}};
         CLS_UNDER: begin
            res_o = {sign_i, {(W-1){1'b0}}};
            udf_o = 1'b1;
         end
         CLS_OVER: begin
            res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf_o = 1'b1;
         end
         default:   res_o = {sign_i, efin[EXP_W-1:0], frac};
      endcase
   end

endmodule

// File: rtl/dfp_mul_core.sv
module dfp_mul_core #(
   parameter int EXP_W       = 11,
   parameter int FRAC_W      = 52,
   parameter int PIPE_STAGES = 2,
   localparam int W          = 1 + EXP_W + FRAC_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] product,
   output logic         ovf,
   output logic         udf
);
   localparam int SIG_W  = FRAC_W + 1;
   localparam int PROD_W = 2 * SIG_W;
   localparam int XE_W   = EXP_W + 2;
   localparam int KEEP_W = FRAC_W + 2;
   localparam int STG_W  = 2 + XE_W + KEEP_W;

   if (PIPE_STAGES < 1) begin : g_bad_pipe
      $error("dfp_mul_core: PIPE_STAGES must be at least 1");
   end
   if (EXP_W < 3 || FRAC_W < 2) begin : g_bad_fmt
      $error("dfp_mul_core: exponent or fraction field too narrow");
   end

   logic                   s_sign, s_zero;
   logic signed [XE_W-1:0] s_exp;
   logic [SIG_W-1:0]       s_sig_a, s_sig_b;
   logic [PROD_W-1:0]      s_prod;
   logic [STG_W-1:0]       s_word;
   logic                   unused_tail;

   logic                   adv;
   logic [STG_W-1:0]       stg_q [PIPE_STAGES];
   logic                   stg_v [PIPE_STAGES];

   logic                   n_sign, n_zero, n_ovf, n_udf;
   logic signed [XE_W-1:0] n_exp;
   logic [KEEP_W-1:0]      n_hi;
   logic [W-1:0]           n_res;

   dfp_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_split (
      .a_i     (op_a),
      .b_i     (op_b),
      .sign_o  (s_sign),
      .zero_o  (s_zero),
      .exp_o   (s_exp),
      .sig_a_o (s_sig_a),
      .sig_b_o (s_sig_b)
   );

   dfp_booth_mul #(.SIG_W(SIG_W)) u_mul (
      .a_i (s_sig_a),
      .b_i (s_sig_b),
      .p_o (s_prod)
   );

   // bits below the cut only feed carries inside the multiplier
   assign unused_tail = ^s_prod[PROD_W-KEEP_W-1:0];
   assign s_word      = {s_sign, s_zero, s_exp, s_prod[PROD_W-1 -: KEEP_W]};

   // one enable for the whole pipe: move when the output slot is free or drains
   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   for (genvar s = 0; s < PIPE_STAGES; s++) begin : g_stage
      logic [STG_W-1:0] d_word;
      logic             d_vld;
      if (s == 0) begin : g_head
         assign d_word = s_word;
         assign d_vld  = in_valid;
      end else begin : g_body
         assign d_word = stg_q[s-1];
         assign d_vld  = stg_v[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   stg_v[s] <= 1'b0;
         else if (adv) stg_v[s] <= d_vld;
      end

      always_ff @(posedge clk) begin
         if (adv) stg_q[s] <= d_word;
      end
   end

   assign {n_sign, n_zero, n_exp, n_hi} = stg_q[PIPE_STAGES-1];

   dfp_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
      .sign_i    (n_sign),
      .zero_i    (n_zero),
      .exp_i     (n_exp),
      .prod_hi_i (n_hi),
      .res_o     (n_res),
      .ovf_o     (n_ovf),
      .udf_o     (n_udf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   out_valid <= 1'b0;
      else if (adv) out_valid <= stg_v[PIPE_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         product <= n_res;
         ovf     <= n_ovf;
         udf     <= n_udf;
      end
   end

endmodule

// File: rtl/dfp_mul_chk.sv
module dfp_mul_chk #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_ready,
   input logic         out_valid,
   input logic         out_ready,
   input logic [W-1:0] product,
   input logic         ovf,
   input logic         udf
);

   // R8
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(product) && $stable(ovf) && $stable(udf)));

   // R8
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // R6
   ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ovf) |-> (product[W-2 -: EXP_W] == '1 && product[FRAC_W-1:0] == '0 && !udf));

   // R7
   udf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && udf) |-> (product[W-2:0] == '0 && !ovf));

   // R5
   zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !ovf && !udf && product[W-2 -: EXP_W] == '0) |-> (product[FRAC_W-1:0] == '0));

endmodule

bind dfp_mul_core dfp_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .product   (product),
   .ovf       (ovf),
   .udf       (udf)
);

// File: tb/sim_dfp_mul_core.sv
module sim_dfp_mul_core;
   localparam int EXP_W = 11;
   localparam int FRAC_W = 52;
   localparam int PIPE = 2;
   localparam int W = 64;
   localparam int WDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0, product;
   logic ovf, udf;

   always #4 clk = ~clk;

   dfp_mul_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .PIPE_STAGES(PIPE)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
      .product(product), .ovf(ovf), .udf(udf));

   int n_chk = 0, n_fail = 0;
   logic [65:0] expq[$];
   string tagq[$];
   string cur_tag = "";

   function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] f);
      return {s, 11'(e), f};
   endfunction

   // independent model: {ovf, udf, result}
   function automatic logic [65:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
      logic s;
      int e;
      logic [105:0] p;
      logic [51:0] f;
      s = a[63] ^ b[63];
      if (a[62:52] == 0 || b[62:52] == 0) return {2'b00, s, 63'd0};
      p = {53'd0, 1'b1, a[51:0]} * {53'd0, 1'b1, b[51:0]};
      e = int'(a[62:52]) + int'(b[62:52]) - 1023;
      if (p[105]) begin e = e + 1; f = p[104:53]; end
      else f = p[103:52];
      if (e >= 2047) return {2'b10, s, 11'h7FF, 52'd0};
      if (e <= 0) return {2'b01, s, 63'd0};
      return {2'b00, s, 11'(e), f};
   endfunction

   function automatic string cls_tag(input logic [63:0] a, input logic [63:0] b, input logic [65:0] e);
      if (a[62:52] == 0 || b[62:52] == 0) return "R5 R1";
      if (e[65]) return "R6 R1";
      if (e[64]) return "R7 R1";
      return "R1 R2 R3 R4";
   endfunction

   task automatic chk(input string tag, input logic [65:0] got, input logic [65:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // scoreboard, sampled mid-cycle; R9 ordering
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && out_ready) begin
            if (expq.size() == 0) chk("R9 spurious result", {ovf, udf, product}, 'x);
            else chk(tagq.pop_front(), {ovf, udf, product}, expq.pop_front());
         end
         if (in_valid && in_ready) begin
            logic [65:0] e;
            e = ref_mul(op_a, op_b);
            expq.push_back(e);
            tagq.push_back(cur_tag != "" ? cur_tag : cls_tag(op_a, op_b, e));
         end
      end
   end

   // starts at posedge+1
   task automatic send(input logic [63:0] a, input logic [63:0] b, input string tag);
      op_a = a; op_b = b; in_valid = 1'b1; cur_tag = tag;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0; cur_tag = "";
   endtask

   function automatic logic [63:0] rnd_op();
      int e;
      e = ($urandom % 16 == 0) ? 0 : int'($urandom % 2048);
      return {1'($urandom), 11'(e), 20'($urandom), 32'($urandom)};
   endfunction

   initial begin
      repeat (WDOG) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8 reset out_valid", {65'd0, out_valid}, 66'd0);
      chk("R8 reset in_ready", {65'd0, in_ready}, 66'd1);
      @(posedge clk); #1;
      out_ready = 1'b1;

      // R8 latency with consumer ready
      begin
         int lat;
         op_a = mk(0, 1023, 52'h0); op_b = mk(1, 1024, 52'h8000000000000);
         in_valid = 1'b1; cur_tag = "R1 R2";
         @(posedge clk); #1;
         in_valid = 1'b0; cur_tag = "";
         lat = 1;
         while (!out_valid && lat < 20) begin @(posedge clk); #1; lat++; end
         chk("R8 latency", 66'(lat), 66'(PIPE + 1));
      end
      repeat (4) @(posedge clk); #1;

      // directed corners
      send($realtobits(25.5), $realtobits(75.6), "R4 truncation");
      send(mk(0, 1023, 52'h8000000000000), mk(0, 1023, 52'h8000000000000), "R3 normalize");
      send(mk(1, 1023, 52'h0), mk(1, 1023, 52'h0), "R1 R2 unit");
      send(mk(1, 0, 52'h0), mk(0, 1500, 52'h123456789ABCD), "R5 zero sign");
      send(mk(0, 1200, 52'h0), mk(1, 0, 52'hFFFF), "R5 denormal as zero");
      send(mk(0, 1535, 52'h8000000000000), mk(0, 1534, 52'h8000000000000), "R6 via increment");
      send(mk(1, 1535, 52'h0), mk(0, 1535, 52'h0), "R6 sum");
      send(mk(0, 1535, 52'h0), mk(0, 1534, 52'h0), "R6 edge 2046 normal");
      send(mk(0, 511, 52'h8000000000000), mk(1, 512, 52'h8000000000000), "R7 rescued");
      send(mk(1, 511, 52'h0), mk(0, 512, 52'h0), "R7 zero no rescue");
      send(mk(0, 511, 52'hFFFFFFFFFFFFF), mk(0, 511, 52'hFFFFFFFFFFFFF), "R7 negative");
      send(mk(0, 1023, 52'hFFFFFFFFFFFFF), mk(0, 1023, 52'hFFFFFFFFFFFFF), "R4 R3 all ones");
      repeat (8) @(posedge clk); #1;

      // random traffic with gaps and output stalls; R9
      for (int c = 0; c < 4000; c++) begin
         logic took;
         @(negedge clk);
         took = in_valid && in_ready;
         @(posedge clk); #1;
         out_ready = ($urandom % 3) != 0;
         if (!in_valid || took) begin
            in_valid = ($urandom % 4) != 0;
            op_a = rnd_op();
            op_b = rnd_op();
         end
      end
      @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
      out_ready = 1'b1;
      repeat (PIPE + 6) @(posedge clk);
      @(negedge clk);
      chk("R9 results outstanding", 66'(expq.size()), 66'd0);
      summary();
      $finish;
   end
endmodule